// File: doc/BRIEF.md
# Matrix Converter Sampling-Period Segment Sequencer

This block runs once per modulation sampling period. It takes five dwell times as clock-cycle counts: four active vectors (am, bm, bn, an) and one zero vector (z). It also takes the output-voltage sector, the input-current sector and a sequence mode. From these it picks the order in which the five segments run inside the period, so that each change of segment needs as few switch commutations as possible.

On a period-start strobe the block latches its inputs and selects one segment order. It loads four compare thresholds with the running sums of the dwell times in that order. A cycle counter then runs from zero, and each threshold raises one step line once the counter reaches it. The number of step lines that are high selects the current segment, which is shown as a one-hot flag for the downstream switch decoder. When the period has run its full length, the block rests in the zero segment until the next strobe.

Top module: `svm_seg_seq`

## Requirements
- R1: While reset is low and right after it is released, only `p_z_o` is high, `st_o` is 0 and `run_o` is 0.
- R2: The parity flag is 1 when the sum of the voltage sector and the current sector (each 1..6) is even, and 0 when the sum is odd. It selects between the two orders of each mode.
- R3: Mode 0 (basic) runs am, bm, bn, an, z when the parity flag is 1, and bm, am, an, bn, z when it is 0.
- R4: Mode 1 (zero first) runs z, am, bm, bn, an when the parity flag is 1, and z, bm, am, an, bn when it is 0.
- R5: Mode 2 (zero in the middle) runs bm, am, z, an, bn when the parity flag is 1, and am, bm, z, bn, an when it is 0.
- R6: Mode 3 (mirrored pairs) uses the basic order in even periods and the reversed basic order in odd periods. Periods are counted by accepted strobes since reset, starting at even. When periods follow back to back, the segment is unchanged across the boundary.
- R7: At cycle offset i of a period, step line k (k = 1..4, bit k-1 of `st_o`) is high exactly when i is at least the sum of the first k dwell times in the chosen order.
- R8: Exactly one of the five segment flags is high on every clock.
- R9: A segment with a zero dwell time never raises its flag in that period.
- R10: After a strobe, `run_o` stays high for exactly as many cycles as the sum of the five dwell times. Each flag is high for its own dwell time. After that the block shows only `p_z_o` with `st_o` equal to 0.
- R11: Changes to the dwell, sector and mode inputs between strobes have no effect on the running period.
- R12: Mode codes 4 to 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Period-start strobe, one cycle |
| dw_am_i | input | W | Dwell of active vector am, cycles |
| dw_bm_i | input | W | Dwell of active vector bm, cycles |
| dw_bn_i | input | W | Dwell of active vector bn, cycles |
| dw_an_i | input | W | Dwell of active vector an, cycles |
| dw_z_i | input | W | Dwell of the zero vector, cycles |
| sec_v_i | input | 3 | Output-voltage sector, 1..6 |
| sec_c_i | input | 3 | Input-current sector, 1..6 |
| mode_i | input | 3 | Sequence mode code |
| st_o | output | 4 | Step lines of the four compare timers |
| p_am_o | output | 1 | Segment flag am |
| p_bm_o | output | 1 | Segment flag bm |
| p_bn_o | output | 1 | Segment flag bn |
| p_an_o | output | 1 | Segment flag an |
| p_z_o | output | 1 | Segment flag z |
| run_o | output | 1 | High while a period is in progress |

## Verification
Directed periods drive each mode with sector pairs of both parities. This separates the two orders within a mode and tells a wrong order apart from a wrong parity decode. Mirrored-mode periods are run back to back, so a missing odd/even alternation or a seam at the boundary shows up in the flag trace. Dwell sets with zeros at the first, middle and last slot, plus an all-zero period, show whether a skipped segment leaks a flag and whether the total length is right. Random dwells, sectors and modes, with inputs scrambled in mid-period, compare the flags and step lines cycle by cycle against a model in the bench.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;

   localparam int NSEG = 5;
   localparam int NTMR = 4;

   typedef enum logic [2:0] {
      SG_AM = 3'd0,
      SG_BM = 3'd1,
      SG_BN = 3'd2,
      SG_AN = 3'd3,
      SG_Z  = 3'd4
   } seg_e;

   typedef logic [3*NSEG-1:0] ord_t;

   localparam logic [2:0] MD_BASIC  = 3'd0;
   localparam logic [2:0] MD_ZFIRST = 3'd1;
   localparam logic [2:0] MD_ZMID   = 3'd2;
   localparam logic [2:0] MD_MIRROR = 3'd3;

   // slot 0 sits in the low three bits
   function automatic ord_t pack5(seg_e s0, seg_e s1, seg_e s2, seg_e s3, seg_e s4);
      return {s4, s3, s2, s1, s0};
   endfunction

   // even sector sum gives 1
   function automatic logic sector_parity(logic [2:0] sv, logic [2:0] sc);
      return ~(sv[0] ^ sc[0]);
   endfunction

   function automatic ord_t pick_order(logic [2:0] md, logic pa, logic odd);
      ord_t r;
      case (md)
         MD_ZFIRST: r = pa ? pack5(SG_Z, SG_AM, SG_BM, SG_BN, SG_AN)
                           : pack5(SG_Z, SG_BM, SG_AM, SG_AN, SG_BN);
         MD_ZMID:   r = pa ? pack5(SG_BM, SG_AM, SG_Z, SG_AN, SG_BN)
                           : pack5(SG_AM, SG_BM, SG_Z, SG_BN, SG_AN);
         MD_MIRROR: begin
            if (odd)
               r = pa ? pack5(SG_Z, SG_AN, SG_BN, SG_BM, SG_AM)
                      : pack5(SG_Z, SG_BN, SG_AN, SG_AM, SG_BM);
            else
               r = pa ? pack5(SG_AM, SG_BM, SG_BN, SG_AN, SG_Z)
                      : pack5(SG_BM, SG_AM, SG_AN, SG_BN, SG_Z);
         end
         default:   r = pa ? pack5(SG_AM, SG_BM, SG_BN, SG_AN, SG_Z)
                           : pack5(SG_BM, SG_AM, SG_AN, SG_BN, SG_Z);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/svm_seq_plan.sv
module svm_seq_plan
   import svm_seq_pkg::*;
#(
   parameter int W  = 12,
   parameter int CW = W + 3
) (
   input  logic [W-1:0]             dw_am,
   input  logic [W-1:0]             dw_bm,
   input  logic [W-1:0]             dw_bn,
   input  logic [W-1:0]             dw_an,
   input  logic [W-1:0]             dw_z,
   input  ord_t                     ord,
   output logic [NTMR-1:0][CW-1:0]  thr,
   output logic [CW-1:0]            total
);

   function automatic logic [CW-1:0] dwell_of(logic [2:0] code);
      logic [W-1:0] v;
      case (code)
         3'd0:    v = dw_am;
         3'd1:    v = dw_bm;
         3'd2:    v = dw_bn;
         3'd3:    v = dw_an;
         default: v = dw_z;
      endcase
      return CW'(v);
   endfunction

   always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int k = 0; k < NTMR; k++) begin
         acc    = acc + dwell_of(ord[3*k +: 3]);
         thr[k] = acc;
      end
      total = acc + dwell_of(ord[3*NTMR +: 3]);
   end

endmodule

// File: rtl/svm_seq_cmp.sv
module svm_seq_cmp #(
   parameter int CW = 15
) (
   input  logic          en,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] thr,
   output logic          hit
);

   assign hit = en && (cnt >= thr);

endmodule

// File: rtl/svm_seq_dec.sv
module svm_seq_dec
   import svm_seq_pkg::*;
(
   input  logic            run,
   input  logic [NTMR-1:0] st,
   input  ord_t            ord,
   output logic [NSEG-1:0] flags
);

   logic [2:0] seg;

   always_comb begin
      case ({st[3], st[2], st[1], st[0]})
         4'b0000: seg = ord[2:0];
         4'b0001: seg = ord[5:3];
         4'b0011: seg = ord[8:6];
         4'b0111: seg = ord[11:9];
         default: seg = ord[14:12];
      endcase
      if (run)
         flags = NSEG'(1) << seg;
      else
         flags = NSEG'(1) << SG_Z;
   end

endmodule

// File: rtl/svm_seg_seq.sv
module svm_seg_seq
   import svm_seq_pkg::*;
#(
   parameter int W = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [W-1:0]  dw_am_i,
   input  logic [W-1:0]  dw_bm_i,
   input  logic [W-1:0]  dw_bn_i,
   input  logic [W-1:0]  dw_an_i,
   input  logic [W-1:0]  dw_z_i,
   input  logic [2:0]    sec_v_i,
   input  logic [2:0]    sec_c_i,
   input  logic [2:0]    mode_i,
   output logic [3:0]    st_o,
   output logic          p_am_o,
   output logic          p_bm_o,
   output logic          p_bn_o,
   output logic          p_an_o,
   output logic          p_z_o,
   output logic          run_o
);

   localparam int CW = W + 3;

   if (W < 2 || W > 28) begin : g_bad_width
      $error("svm_seg_seq: W must lie in 2..28");
   end

   ord_t                    ord_n, ord_q;
   logic [NTMR-1:0][CW-1:0] thr_n, thr_q;
   logic [CW-1:0]           tot_n, tot_q, cnt_q;
   logic                    run_q, ph_q;
   logic [NTMR-1:0]         st;
   logic [NSEG-1:0]         flags;

   assign ord_n = pick_order(mode_i, sector_parity(sec_v_i, sec_c_i), ph_q);

   svm_seq_plan #(.W(W), .CW(CW)) u_plan (
      .dw_am (dw_am_i),
      .dw_bm (dw_bm_i),
      .dw_bn (dw_bn_i),
      .dw_an (dw_an_i),
      .dw_z  (dw_z_i),
      .ord   (ord_n),
      .thr   (thr_n),
      .total (tot_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord_q <= pack5(SG_AM, SG_BM, SG_BN, SG_AN, SG_Z);
         thr_q <= '0;
         tot_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         ph_q  <= 1'b0;
      end else if (start_i) begin
         ord_q <= ord_n;
         thr_q <= thr_n;
         tot_q <= tot_n;
         cnt_q <= '0;
         run_q <= (tot_n != '0);
         ph_q  <= ~ph_q;
      end else if (run_q) begin
         if (cnt_q == tot_q - CW'(1))
            run_q <= 1'b0;
         else
            cnt_q <= cnt_q + CW'(1);
      end
   end

   for (genvar k = 0; k < NTMR; k++) begin : g_tmr
      svm_seq_cmp #(.CW(CW)) u_cmp (
         .en  (run_q),
         .cnt (cnt_q),
         .thr (thr_q[k]),
         .hit (st[k])
      );
   end

   svm_seq_dec u_dec (
      .run   (run_q),
      .st    (st),
      .ord   (ord_q),
      .flags (flags)
   );

   assign st_o   = st;
   assign p_am_o = flags[SG_AM];
   assign p_bm_o = flags[SG_BM];
   assign p_bn_o = flags[SG_BN];
   assign p_an_o = flags[SG_AN];
   assign p_z_o  = flags[SG_Z];
   assign run_o  = run_q;

endmodule

// File: rtl/svm_seg_seq_chk.sv
module svm_seg_seq_chk
   import svm_seq_pkg::*;
#(
   parameter int CW = 15
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic                    run_o,
   input logic [3:0]              st_o,
   input logic                    p_am_o,
   input logic                    p_bm_o,
   input logic                    p_bn_o,
   input logic                    p_an_o,
   input logic                    p_z_o,
   input logic [NTMR-1:0][CW-1:0] thr_q
);

   logic [NSEG-1:0] fl;
   assign fl = {p_z_o, p_an_o, p_bn_o, p_bm_o, p_am_o};

   assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fl) == 1);

   // step lines rise in order: a higher one never leads a lower one
   assert_step_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o[3:1] & ~st_o[2:0]) == 3'b000);

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |-> (p_z_o && st_o == 4'b0000));

   assert_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !start_i) |=> $stable(thr_q));

endmodule

bind svm_seg_seq svm_seg_seq_chk #(.CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .run_o   (run_o),
   .st_o    (st_o),
   .p_am_o  (p_am_o),
   .p_bm_o  (p_bm_o),
   .p_bn_o  (p_bn_o),
   .p_an_o  (p_an_o),
   .p_z_o   (p_z_o),
   .thr_q   (thr_q)
);

// File: tb/sim_svm_seg_seq.sv
module sim_svm_seg_seq;

   localparam int CLK_PER = 10;
   localparam int W       = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] dw_am_i = '0, dw_bm_i = '0, dw_bn_i = '0, dw_an_i = '0, dw_z_i = '0;
   logic [2:0]   sec_v_i = 3'd1, sec_c_i = 3'd1, mode_i = 3'd0;
   logic [3:0]   st_o;
   logic         p_am_o, p_bm_o, p_bn_o, p_an_o, p_z_o, run_o;

   always #(CLK_PER/2) clk = ~clk;

   svm_seg_seq #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .dw_am_i(dw_am_i), .dw_bm_i(dw_bm_i), .dw_bn_i(dw_bn_i),
      .dw_an_i(dw_an_i), .dw_z_i(dw_z_i),
      .sec_v_i(sec_v_i), .sec_c_i(sec_c_i), .mode_i(mode_i),
      .st_o(st_o), .p_am_o(p_am_o), .p_bm_o(p_bm_o), .p_bn_o(p_bn_o),
      .p_an_o(p_an_o), .p_z_o(p_z_o), .run_o(run_o)
   );

   int  n_run = 0, n_fail = 0;
   bit  done = 1'b0;
   int  bph = 0;

   // codes: am 0, bm 1, bn 2, an 3, z 4
   int nx_d[5];  int nx_sv, nx_sc, nx_md;
   int pd_d[5];  int pd_sv, pd_sc, pd_md, pd_odd;

   function automatic logic [4:0] flags_now();
      return {p_z_o, p_an_o, p_bn_o, p_bm_o, p_am_o};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   function automatic string mode_tag(input int md);
      case (md)
         1: return "R4";
         2: return "R5";
         3: return "R6";
         0: return "R3";
         default: return "R12";
      endcase
   endfunction

   // independent model of the segment orders
   task automatic model_order(input int md, input int sv, input int sc, input int odd,
                              output int o[5]);
      bit even = ((sv + sc) % 2) == 0;   // R2
      int fwd1[5] = '{0, 1, 2, 3, 4};
      int fwd0[5] = '{1, 0, 3, 2, 4};
      int m = (md > 3) ? 0 : md;
      for (int k = 0; k < 5; k++) begin
         case (m)
            1: o[k] = (k == 0) ? 4 : (even ? fwd1[k-1] : fwd0[k-1]);
            2: begin
               int zm1[5] = '{1, 0, 4, 3, 2};
               int zm0[5] = '{0, 1, 4, 2, 3};
               o[k] = even ? zm1[k] : zm0[k];
            end
            3: o[k] = odd ? (even ? fwd1[4-k] : fwd0[4-k]) : (even ? fwd1[k] : fwd0[k]);
            default: o[k] = even ? fwd1[k] : fwd0[k];
         endcase
      end
   endtask

   task automatic launch();
      dw_am_i = W'(nx_d[0]); dw_bm_i = W'(nx_d[1]); dw_bn_i = W'(nx_d[2]);
      dw_an_i = W'(nx_d[3]); dw_z_i  = W'(nx_d[4]);
      sec_v_i = 3'(nx_sv); sec_c_i = 3'(nx_sc); mode_i = 3'(nx_md);
      start_i = 1'b1;
      pd_d = nx_d; pd_sv = nx_sv; pd_sc = nx_sc; pd_md = nx_md;
      pd_odd = bph; bph ^= 1;
   endtask

   // called at the negedge just after the strobe edge
   task automatic observe(input bit chain);
      int d[5]; int o[5]; int len[5]; int T; int cum[5]; int md;
      d = pd_d; md = pd_md;
      model_order(pd_md, pd_sv, pd_sc, pd_odd, o);
      start_i = 1'b0;
      // R11: scramble inputs while the period runs
      dw_am_i = W'($urandom); dw_bm_i = W'($urandom); dw_bn_i = W'($urandom);
      dw_an_i = W'($urandom); dw_z_i = W'($urandom);
      sec_v_i = 3'($urandom_range(1, 6)); sec_c_i = 3'($urandom_range(1, 6));
      mode_i  = 3'($urandom);
      cum[0] = 0;
      for (int k = 1; k < 5; k++) cum[k] = cum[k-1] + d[o[k-1]];
      T = cum[4] + d[o[4]];
      for (int s = 0; s < 5; s++) len[s] = 0;
      for (int i = 0; i < T; i++) begin
         int es = 4; int acc = 0; bit found = 0;
         logic [3:0] est;
         logic [4:0] f;
         for (int k = 0; k < 5; k++) begin
            acc += d[o[k]];
            if (!found && i < acc) begin es = o[k]; found = 1; end
         end
         for (int k = 0; k < 4; k++) est[k] = (i >= cum[k+1]);
         f = flags_now();
         check(f == 5'(1 << es), mode_tag(md), int'(f), 1 << es);
         check(st_o == est, "R7", int'(st_o), int'(est));
         check($countones(f) == 1, "R8", $countones(f), 1);
         check(run_o == 1'b1, "R10", int'(run_o), 1);
         if (i == 0 && md == 0 && d[0] > 0 && d[1] > 0) begin
            int want = (((pd_sv + pd_sc) % 2) == 0) ? 1 : 2;
            check(int'(f[1:0]) == want, "R2", int'(f[1:0]), want);
         end
         for (int s = 0; s < 5; s++) if (f[s]) len[s]++;
         if (i == T - 1 && chain) launch();
         @(negedge clk);
      end
      for (int s = 0; s < 5; s++)
         check(len[s] == d[s], (d[s] == 0) ? "R9" : "R10", len[s], d[s]);
      check(len[0] + len[1] + len[2] + len[3] + len[4] == T, "R11", 
            len[0] + len[1] + len[2] + len[3] + len[4], T);
      if (!chain || T == 0) begin
         check(run_o == 1'b0 && p_z_o && st_o == 4'b0000, "R10",
               int'({run_o, p_z_o, st_o}), int'(6'b010000));
      end
   endtask

   task automatic set_nx(input int a, input int b, input int c, input int e, input int z,
                         input int sv, input int sc, input int md);
      nx_d = '{a, b, c, e, z}; nx_sv = sv; nx_sc = sc; nx_md = md;
   endtask

   task automatic step(input bit chain_req);
      int tp = pd_d[0] + pd_d[1] + pd_d[2] + pd_d[3] + pd_d[4];
      bit chain = chain_req && (tp > 0);
      observe(chain);
      if (!chain) begin
         launch();
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4021));
      repeat (3) @(negedge clk);
      check(p_z_o && st_o == 4'b0000 && !run_o, "R1", int'({p_z_o, st_o, run_o}), int'(6'b100000));
      rst_n = 1'b1;
      @(negedge clk);
      check(p_z_o && st_o == 4'b0000 && !run_o, "R1", int'({p_z_o, st_o, run_o}), int'(6'b100000));

      set_nx(3, 4, 5, 2, 6, 1, 1, 0); launch(); @(negedge clk);   // R3 even
      set_nx(3, 4, 5, 2, 6, 1, 2, 0); step(0);                      // R3 odd
      set_nx(2, 3, 4, 5, 3, 2, 4, 1); step(0);                      // R4 even
      set_nx(2, 3, 4, 5, 3, 5, 2, 1); step(0);                      // R4 odd
      set_nx(4, 1, 2, 3, 5, 3, 3, 2); step(0);                      // R5 even
      set_nx(4, 1, 2, 3, 5, 3, 6, 2); step(0);                      // R5 odd
      set_nx(3, 2, 4, 1, 4, 1, 1, 3); step(0);                      // R6 pair, back to back
      set_nx(3, 2, 4, 1, 4, 1, 1, 3); step(1);
      set_nx(2, 5, 1, 3, 2, 4, 1, 3); step(1);
      set_nx(0, 3, 0, 2, 0, 6, 6, 0); step(0);                      // R9 zeros
      set_nx(5, 0, 3, 0, 2, 2, 2, 1); step(0);
      set_nx(2, 2, 2, 2, 2, 1, 4, 6); step(0);                      // R12
      set_nx(0, 0, 0, 0, 0, 1, 1, 2); step(0);                      // empty period
      set_nx(1, 1, 1, 1, 1, 2, 5, 5); step(0);
      for (int r = 0; r < 80; r++) begin
         int dz[5];
         for (int s = 0; s < 5; s++)
            dz[s] = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 12);
         set_nx(dz[0], dz[1], dz[2], dz[3], dz[4],
                $urandom_range(1, 6), $urandom_range(1, 6), $urandom_range(0, 7));
         step(1'($urandom_range(0, 1)));
      end
      observe(0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule